// File: doc/BRIEF.md
# Hypercube Node Router with Fixed Dimension Order

This block is one node of a binary hypercube network of `2**DIM` nodes that share no memory and talk only by sending messages over point-to-point links. The node has `DIM` link ports, one per address bit, plus one local port through which its own processing element injects and receives messages. Link `k` leads to the neighbour whose address differs from this node's address in bit `k` alone.

Each message is a single flit that carries a destination address and a payload. Every input holds at most one flit in a register. The router XORs the destination with the node's own address. If the result is zero, the flit leaves on the local port. Otherwise it leaves on the link given by the lowest set bit of the XOR. Each hop therefore corrects one address bit in ascending bit order, so no route is longer than `DIM` hops. When several inputs want the same output, a round-robin arbiter picks one of them and the others wait.

Top module: `hcube_router_node`

## Requirements
- R1: After reset every `out_valid` bit is low and every `in_ready` bit is high.
- R2: A flit whose destination equals `NODE_ID` leaves only on port index `DIM`, which is the local port.
- R3: A flit whose destination differs from `NODE_ID` leaves only on link `k`, where `k` is the lowest set bit of destination XOR `NODE_ID`. Port indices `0..DIM-1` are the links.
- R4: A flit enters only in a cycle where `in_valid` and `in_ready` are both high, and it leaves only in a cycle where `out_valid` and `out_ready` are both high. Each accepted flit leaves exactly once. A flit offered while `in_ready` is low is ignored.
- R5: While `out_valid` is high and `out_ready` is low on a port, `out_valid` stays high on that port and its flit does not change.
- R6: When several inputs hold flits for the same output, the arbiter grants them in round-robin order. An input that has just been granted loses to a waiting input the next time both compete.
- R7: Each input holds one flit. While it holds a flit that is not leaving in the current cycle, its `in_ready` is low.
- R8: A flit is `PAY_W + DIM` bits wide. The destination address sits in the top `DIM` bits and the payload in the low `PAY_W` bits. A flit is forwarded bit for bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | DIM+1 | Per input port: a flit is offered |
| in_flit | input | (DIM+1)*(DIM+PAY_W) | Flits offered on the inputs; port `i` uses slice `i` |
| in_ready | output | DIM+1 | Per input port: the node can take a flit |
| out_valid | output | DIM+1 | Per output port: a flit is presented |
| out_flit | output | (DIM+1)*(DIM+PAY_W) | Flits presented on the outputs; port `o` uses slice `o` |
| out_ready | input | DIM+1 | Per output port: the neighbour can take a flit |

## Verification
The bench configures an 8-node cube and sweeps every input port against every destination address. The expected output port is computed arithmetically, which separates local delivery from each link choice and confirms that each flit leaves exactly once. A three-way contention on one link with that output stalled checks back-pressure, output stability, and that a flit offered to a full input is ignored. In a two-input contention the winner offers a fresh flit in the very cycle it is served. A fair arbiter must then serve the waiting input first, whereas a fixed-priority arbiter would serve the winner again, so this test tells the two apart.

// File: rtl/hc_pkg.sv
package hc_pkg;
   localparam int HC_MAX_DIM = 12;

   function automatic int hc_ptr_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/hc_route_calc.sv
module hc_route_calc #(
   parameter int DIM     = 3,
   parameter int NODE_ID = 0,
   localparam int NPORT  = DIM + 1
) (
   input  logic [DIM-1:0]   dest,
   output logic [NPORT-1:0] port_sel
);
   localparam logic [DIM-1:0] SELF = DIM'(NODE_ID);

   logic [DIM-1:0] diff;
   assign diff = dest ^ SELF;

   // local port when nothing differs
   assign port_sel[DIM] = (diff == '0);

   genvar k;
   generate
      for (k = 0; k < DIM; k++) begin : g_link
         if (k == 0) begin : g_first
            assign port_sel[k] = diff[0];
         end else begin : g_rest
            assign port_sel[k] = diff[k] & (diff[k-1:0] == '0);
         end
      end
   endgenerate
endmodule

// File: rtl/hc_in_slot.sv
module hc_in_slot #(
   parameter int FW = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [FW-1:0] in_flit,
   output logic          in_ready,
   input  logic          deq,
   output logic          full,
   output logic [FW-1:0] flit
);
   logic          full_q;
   logic [FW-1:0] data_q;
   logic          load;

   assign in_ready = ~full_q | deq;
   assign load     = in_valid & in_ready;
   assign full     = full_q;
   assign flit     = data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_q <= 1'b0;
         data_q <= '0;
      end else begin
         if (load) begin
            full_q <= 1'b1;
            data_q <= in_flit;
         end else if (deq) begin
            full_q <= 1'b0;
         end
      end
   end

   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (full_q && !deq) |=> (full_q && $stable(data_q)));

   assert_idle_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!full_q && !in_valid) |=> !full_q);

   assert_deq_needs_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
      deq |-> full_q);
endmodule

// File: rtl/hc_rr_arb.sv
module hc_rr_arb #(
   parameter int NREQ = 4,
   localparam int PW  = hc_pkg::hc_ptr_w(NREQ)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NREQ-1:0] req,
   input  logic            take,
   output logic [NREQ-1:0] grant
);
   logic [PW-1:0]   ptr_q;
   logic            hold_q;
   logic [NREQ-1:0] held_q;
   logic [NREQ-1:0] rr_gnt;
   int              rr_idx;

   always_comb begin
      rr_gnt = '0;
      rr_idx = 0;
      for (int off = NREQ - 1; off >= 0; off--) begin
         int idx;
         idx = int'(ptr_q) + off;
         if (idx >= NREQ) idx = idx - NREQ;
         if (req[idx]) begin
            rr_gnt = '0;
            rr_gnt[idx] = 1'b1;
            rr_idx = idx;
         end
      end
   end

   // keep a stalled grant so the presented flit cannot change
   assign grant = hold_q ? held_q : rr_gnt;

   int gnt_idx;
   always_comb begin
      gnt_idx = 0;
      for (int i = 0; i < NREQ; i++) begin
         if (grant[i]) gnt_idx = i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q  <= '0;
         hold_q <= 1'b0;
         held_q <= '0;
      end else begin
         hold_q <= (|grant) & ~take;
         held_q <= grant;
         if ((|grant) && take) begin
            ptr_q <= (gnt_idx == NREQ - 1) ? '0 : PW'(gnt_idx + 1);
         end
      end
   end

   assert_onehot_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   assert_grant_has_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((grant & ~req) == '0));

   assert_work_conserving_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (|req) |-> (|grant));
endmodule

// File: rtl/hcube_router_node.sv
module hcube_router_node #(
   parameter int DIM     = 3,
   parameter int PAY_W   = 8,
   parameter int NODE_ID = 0,
   localparam int NPORT  = DIM + 1,
   localparam int FW     = DIM + PAY_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NPORT-1:0]    in_valid,
   input  logic [NPORT*FW-1:0] in_flit,
   output logic [NPORT-1:0]    in_ready,
   output logic [NPORT-1:0]    out_valid,
   output logic [NPORT*FW-1:0] out_flit,
   input  logic [NPORT-1:0]    out_ready
);
   generate
      if (DIM < 1 || DIM > hc_pkg::HC_MAX_DIM) begin : g_bad_dim
         $error("hcube_router_node: DIM out of range");
      end
      if (PAY_W < 1) begin : g_bad_pay
         $error("hcube_router_node: PAY_W must be positive");
      end
      if (NODE_ID < 0 || NODE_ID >= (1 << DIM)) begin : g_bad_id
         $error("hcube_router_node: NODE_ID does not fit DIM bits");
      end
   endgenerate

   logic [NPORT-1:0] slot_full;
   logic [FW-1:0]    slot_flit [NPORT];
   logic [NPORT-1:0] slot_sel  [NPORT];
   logic [NPORT-1:0] slot_deq;
   logic [NPORT-1:0] arb_req   [NPORT];
   logic [NPORT-1:0] arb_gnt   [NPORT];

   genvar i, o;
   generate
      for (i = 0; i < NPORT; i++) begin : g_in
         hc_in_slot #(.FW(FW)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_valid (in_valid[i]),
            .in_flit  (in_flit[i*FW +: FW]),
            .in_ready (in_ready[i]),
            .deq      (slot_deq[i]),
            .full     (slot_full[i]),
            .flit     (slot_flit[i])
         );

         hc_route_calc #(.DIM(DIM), .NODE_ID(NODE_ID)) u_route (
            .dest     (slot_flit[i][FW-1 -: DIM]),
            .port_sel (slot_sel[i])
         );
      end

      for (o = 0; o < NPORT; o++) begin : g_out
         for (i = 0; i < NPORT; i++) begin : g_req
            assign arb_req[o][i] = slot_full[i] & slot_sel[i][o];
         end

         hc_rr_arb #(.NREQ(NPORT)) u_arb (
            .clk   (clk),
            .rst_n (rst_n),
            .req   (arb_req[o]),
            .take  (out_ready[o]),
            .grant (arb_gnt[o])
         );

         logic [FW-1:0] mux_flit;
         always_comb begin
            mux_flit = '0;
            for (int s = 0; s < NPORT; s++) begin
               if (arb_gnt[o][s]) mux_flit = mux_flit | slot_flit[s];
            end
         end

         assign out_valid[o]           = |arb_gnt[o];
         assign out_flit[o*FW +: FW]   = mux_flit;

         assert_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[o] && !out_ready[o]) |=>
               (out_valid[o] && $stable(out_flit[o*FW +: FW])));

         if (o == DIM) begin : g_chk_local
            assert_local_dest_R2: assert property (@(posedge clk) disable iff (!rst_n)
               out_valid[o] |-> (out_flit[o*FW + FW - 1 -: DIM] == DIM'(NODE_ID)));
         end else begin : g_chk_link
            localparam logic [DIM-1:0] SELF = DIM'(NODE_ID);
            assert_link_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
               out_valid[o] |-> (out_flit[o*FW + PAY_W + o] != SELF[o]));
            if (o > 0) begin : g_low
               assert_link_lower_R3: assert property (@(posedge clk) disable iff (!rst_n)
                  out_valid[o] |->
                     (out_flit[o*FW + PAY_W +: o] == SELF[o-1:0]));
            end
         end
      end
   endgenerate

   always_comb begin
      slot_deq = '0;
      for (int s = 0; s < NPORT; s++) begin
         for (int p = 0; p < NPORT; p++) begin
            slot_deq[s] = slot_deq[s] | (arb_gnt[p][s] & out_ready[p]);
         end
      end
   end
endmodule

// File: tb/hcube_router_node_tb.sv
module hcube_router_node_tb;
   localparam int DIM   = 3;
   localparam int PAY_W = 8;
   localparam int SELF  = 5;
   localparam int NP    = DIM + 1;
   localparam int FW    = DIM + PAY_W;

   logic             clk = 1'b0;
   logic             rst_n;
   logic [NP-1:0]    in_valid;
   logic [NP*FW-1:0] in_flit;
   logic [NP-1:0]    in_ready;
   logic [NP-1:0]    out_valid;
   logic [NP*FW-1:0] out_flit;
   logic [NP-1:0]    out_ready;

   int  n_run  = 0;
   int  n_fail = 0;
   bit  done   = 1'b0;

   always #2 clk = ~clk;

   hcube_router_node #(.DIM(DIM), .PAY_W(PAY_W), .NODE_ID(SELF)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_flit   (in_flit),
      .in_ready  (in_ready),
      .out_valid (out_valid),
      .out_flit  (out_flit),
      .out_ready (out_ready)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   function automatic int exp_port(input int dest);
      int x;
      x = dest ^ SELF;
      if (x == 0) return DIM;
      for (int b = 0; b < DIM; b++) begin
         if (x[b]) return b;
      end
      return DIM;
   endfunction

   function automatic logic [FW-1:0] mk(input int dest, input int pay);
      return {DIM'(dest), PAY_W'(pay)};
   endfunction

   function automatic logic [FW-1:0] oslice(input int o);
      return out_flit[o*FW +: FW];
   endfunction

   initial begin
      rst_n = 1'b0;
      in_valid = '0;
      in_flit = '0;
      out_ready = '1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(out_valid == '0, "R1 out_valid after reset", out_valid, 0);
      check(in_ready == '1, "R1 in_ready after reset", in_ready, 4'hF);

      // sweep: every input port x every destination
      for (int p = 0; p < NP; p++) begin
         for (int d = 0; d < (1 << DIM); d++) begin
            int e;
            int pay;
            e = exp_port(d);
            pay = p * 16 + d + 1;
            in_valid[p] = 1'b1;
            in_flit[p*FW +: FW] = mk(d, pay);
            check(in_ready[p] == 1'b1, "R7 empty input ready", in_ready[p], 1);
            @(negedge clk);
            in_valid = '0;
            if (e == DIM)
               check(out_valid == NP'(1 << e), "R2 local port choice", out_valid, 1 << e);
            else
               check(out_valid == NP'(1 << e), "R3 link choice", out_valid, 1 << e);
            check(oslice(e) == mk(d, pay), "R8 flit unchanged", oslice(e), mk(d, pay));
            @(negedge clk);
            check(out_valid == '0, "R4 forwarded exactly once", out_valid, 0);
         end
      end

      // three-way contention on link 0 with that output stalled
      begin
         int dst;
         logic [FW-1:0] first;
         int seen [3];
         dst = SELF ^ 1;
         out_ready = '0;
         for (int p = 0; p < 3; p++) begin
            in_valid[p] = 1'b1;
            in_flit[p*FW +: FW] = mk(dst, 8'hA0 + p);
            seen[p] = 0;
         end
         @(negedge clk);
         in_valid = '0;
         check(in_ready[2:0] == 3'b000, "R7 full inputs not ready", in_ready[2:0], 0);
         check(out_valid == 4'b0001, "R3 contended link valid", out_valid, 1);
         first = oslice(0);
         in_valid[0] = 1'b1;
         in_flit[0*FW +: FW] = mk(dst, 8'hEE);
         @(negedge clk);
         in_valid = '0;
         check(out_valid[0] == 1'b1, "R5 valid held while stalled", out_valid[0], 1);
         check(oslice(0) == first, "R5 flit stable while stalled", oslice(0), first);
         out_ready[0] = 1'b1;
         for (int c = 0; c < 3; c++) begin
            logic [PAY_W-1:0] pl;
            pl = oslice(0)[PAY_W-1:0];
            check(out_valid[0] == 1'b1, "R6 contender served", out_valid[0], 1);
            check(pl != 8'hEE, "R4 offer to full input ignored", pl, 8'hA0);
            if (pl >= 8'hA0 && pl <= 8'hA2) seen[pl - 8'hA0]++;
            @(negedge clk);
         end
         for (int p = 0; p < 3; p++)
            check(seen[p] == 1, "R6 each contender served once", seen[p], 1);
         check(out_valid == '0, "R4 nothing extra after drain", out_valid, 0);
      end

      // fairness: winner re-offers in the cycle it is served
      begin
         int dst;
         int w;
         int l;
         dst = SELF ^ 1;
         out_ready = '0;
         in_valid[1] = 1'b1;
         in_flit[1*FW +: FW] = mk(dst, 8'h51);
         in_valid[3] = 1'b1;
         in_flit[3*FW +: FW] = mk(dst, 8'h53);
         @(negedge clk);
         in_valid = '0;
         w = (oslice(0)[PAY_W-1:0] == 8'h51) ? 1 : 3;
         l = (w == 1) ? 3 : 1;
         out_ready[0] = 1'b1;
         in_valid[w] = 1'b1;
         in_flit[w*FW +: FW] = mk(dst, 8'h77);
         #0;
         check(in_ready[w] == 1'b1, "R7 ready while leaving", in_ready[w], 1);
         @(negedge clk);
         in_valid = '0;
         check(oslice(0)[PAY_W-1:0] == PAY_W'(8'h50 + l), "R6 waiting input goes next",
               oslice(0)[PAY_W-1:0], 8'h50 + l);
         @(negedge clk);
         check(oslice(0)[PAY_W-1:0] == 8'h77, "R6 re-offered flit after",
               oslice(0)[PAY_W-1:0], 8'h77);
         @(negedge clk);
         check(out_valid == '0, "R4 drained", out_valid, 0);
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(4 * 20000);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule